// File: doc/BRIEF.md
# PLL Power-Up and Lock Sequencer

This block walks a phase-locked loop through power-up and power-down as a fixed series of control-bit actions, one action per clock. It also mirrors the bias, clock-gate and buffer steps onto an optional paired slave instance. A power-up request turns on the bias and the system-mux routing, which is the value 0xC0 on an 8-bit output. The slave gets the same bias step at the same time. After a settle wait the block starts the PLL. It then samples the lock-status input every 100 microsecond ticks, with a hard limit of 5000 ticks. Once lock is seen it marks the PLL on, opens the output clock gates and then the readback buffers.

A power-down request reverses this with glitch safety in mind. The output clock gate closes before the PLL start bit drops, so no partial clock reaches a consumer. After that the buffer, mux and bias are removed, a settle wait follows, and the slave is dismantled the same way. The settle wait lasts 250 ns and is counted in reference-clock cycles from a frequency parameter. The microsecond tick is an input.

Top module: `pll_power_seq`

## Requirements
- R1: A power-up request accepted in the idle or error state sets master bias to 1 and master mux to 0xC0 in one cycle. If the slave is present, slave bias and slave mux (0xC0) change in that same cycle. The error flag clears in that same cycle.
- R2: The PLL start output rises exactly WAIT_CYC cycles after the bias step, where WAIT_CYC = ceil(250 * REF_CLK_MHZ / 1000), with a minimum of 1.
- R3: While polling, the block counts microsecond ticks and samples lock on every 100th tick. The on status rises at the first sample that sees lock, so the tick count at that moment is 100 * ceil((D+1)/100) when lock rises after D ticks.
- R4: If the 50th sample (tick 5000) still sees no lock, the error flag rises, the on status stays 0, no done pulse is given, and the start and bias outputs are held.
- R5: One cycle after the on status rises, the master clock gate opens, and the slave gate opens with it when the slave is present. One cycle later both readback buffers are enabled and done pulses for exactly one cycle.
- R6: Requests that arrive while a sequence runs are ignored. A power-up request while on and a power-down request while idle are ignored, and the outputs do not change.
- R7: On a power-down request while on, the master clock gate closes first and the PLL start output clears one cycle later.
- R8: After start clears, the master buffer, master mux and master bias clear one per cycle. A WAIT_CYC settle wait follows. With no slave, the on status clears and done pulses once the wait ends.
- R9: With a slave, once the master wait ends, the slave clock gate, slave buffer, slave mux and slave bias clear one per cycle. A second WAIT_CYC wait follows, and then the on status clears and done pulses.
- R10: The error flag stays set, including through a power-down, until the next accepted power-up request. A power-down request from the error state runs the shutdown sequence.
- R11: The slave-present input is captured when a power-up request is accepted. Later changes to it do not affect that power-up or the following power-down.
- R12: After reset every control output, the on status, the error flag and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prepare_i | input | 1 | Power-up request |
| unprepare_i | input | 1 | Power-down request |
| slave_present_i | input | 1 | A paired slave instance is attached |
| lock_i | input | 1 | PLL lock-status bit |
| us_tick_i | input | 1 | One-cycle pulse every microsecond |
| m_bias_en_o | output | 1 | Master bias enable |
| m_sys_mux_o | output | 8 | Master system-mux control (0xC0 on, 0x00 off) |
| pll_start_o | output | 1 | PLL start control |
| m_clk_en_o | output | 1 | Master global output clock enable |
| m_rbuf_en_o | output | 1 | Master readback-buffer enable |
| s_bias_en_o | output | 1 | Slave bias enable |
| s_sys_mux_o | output | 8 | Slave system-mux control |
| s_clk_en_o | output | 1 | Slave global output clock enable |
| s_rbuf_en_o | output | 1 | Slave readback-buffer enable |
| pll_on_o | output | 1 | PLL marked on |
| done_o | output | 1 | One-cycle pulse at the end of a successful power-up or power-down |
| err_o | output | 1 | Lock timeout flag |

## Verification
The bench targets four kinds of error.

- **Lock-window edges.** It uses lock delays of 0, 100, 250 and 4999 ticks, plus a case with no lock. A poll counter that is off by one would mark the PLL on one poll late. It would also turn the 4999-tick case into a false timeout or a late timeout.
- **Step order.** Every output change is compared in order against an expected queue, together with the cycle gap to the change before it. A design that powered down the PLL before gating its clock would be caught, and so would one that merged two teardown steps. A settle wait that is short or long by a cycle would also show.
- **Ignored requests.** Requests are injected mid-poll, while on and while idle, and the slave-present input is flipped after acceptance. A restarted or re-steered sequence would either produce unexpected output changes or skip the slave teardown.
- **Error lifetime.** The error flag is checked across a full shutdown. A design that cleared it early would be reported.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam logic [7:0] MUX_ROUTE_ON  = 8'hC0;
    localparam logic [7:0] MUX_ROUTE_OFF = 8'h00;

    typedef enum logic [3:0] {
        S_IDLE,
        S_BIAS_WAIT,
        S_POLL,
        S_CLK_OPEN,
        S_BUF_OPEN,
        S_ON,
        S_FAIL,
        S_DN_STOP,
        S_DN_MBUF,
        S_DN_MMUX,
        S_DN_MBIAS,
        S_DN_MWAIT,
        S_DN_SBUF,
        S_DN_SMUX,
        S_DN_SBIAS,
        S_DN_SWAIT
    } seq_state_e;

    typedef struct packed {
        logic       bias;
        logic [7:0] mux;
        logic       clk_en;
        logic       rbuf;
    } side_ctl_t;

    typedef struct packed {
        seq_state_e state;
        side_ctl_t  m;
        side_ctl_t  s;
        logic       start;
        logic       on;
        logic       err;
        logic       done;
        logic       slave;
    } seq_regs_t;

endpackage

// File: rtl/pll_seq_settle.sv
module pll_seq_settle #(
    parameter int WAIT_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic expire_o
);
    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } settle_t;

    settle_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start_i) begin
            r_d.busy = 1'b1;
            r_d.cnt  = '0;
        end else if (r_q.busy) begin
            if (r_q.cnt == LAST) begin
                r_d.busy = 1'b0;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign expire_o = r_q.busy && (r_q.cnt == LAST);

endmodule

// File: rtl/pll_seq_poll.sv
module pll_seq_poll #(
    parameter int POLL_US    = 100,
    parameter int TIMEOUT_US = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic active_i,
    input  logic us_tick_i,
    output logic sample_o,
    output logic last_o
);
    localparam int NPOLL  = (TIMEOUT_US / POLL_US > 0) ? TIMEOUT_US / POLL_US : 1;
    localparam int TICK_W = (POLL_US > 1) ? $clog2(POLL_US) : 1;
    localparam int IDX_W  = (NPOLL > 1) ? $clog2(NPOLL) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(POLL_US - 1);
    localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(NPOLL - 1);

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic [IDX_W-1:0]  idx;
    } poll_t;

    poll_t r_d, r_q;
    logic  hit;

    assign hit = active_i && us_tick_i && (r_q.tick == TICK_LAST);

    always_comb begin
        r_d = r_q;
        if (clear_i) begin
            r_d = '0;
        end else if (active_i && us_tick_i) begin
            if (hit) begin
                r_d.tick = '0;
                if (r_q.idx != IDX_LAST) begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end else begin
                r_d.tick = r_q.tick + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sample_o = hit;
    assign last_o   = (r_q.idx == IDX_LAST);

endmodule

// File: rtl/pll_power_seq.sv
module pll_power_seq
    import pll_seq_pkg::*;
#(
    parameter int REF_CLK_MHZ     = 100,
    parameter int SETTLE_NS       = 250,
    parameter int POLL_US         = 100,
    parameter int LOCK_TIMEOUT_US = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prepare_i,
    input  logic       unprepare_i,
    input  logic       slave_present_i,
    input  logic       lock_i,
    input  logic       us_tick_i,
    output logic       m_bias_en_o,
    output logic [7:0] m_sys_mux_o,
    output logic       pll_start_o,
    output logic       m_clk_en_o,
    output logic       m_rbuf_en_o,
    output logic       s_bias_en_o,
    output logic [7:0] s_sys_mux_o,
    output logic       s_clk_en_o,
    output logic       s_rbuf_en_o,
    output logic       pll_on_o,
    output logic       done_o,
    output logic       err_o
);
    localparam int WAIT_RAW = (SETTLE_NS * REF_CLK_MHZ + 999) / 1000;
    localparam int WAIT_CYC = (WAIT_RAW > 0) ? WAIT_RAW : 1;

    seq_regs_t st_d, st_q;
    logic      settle_go, settle_end;
    logic      poll_clr, poll_active, poll_hit, poll_last;

    pll_seq_settle #(.WAIT_CYC(WAIT_CYC)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (settle_go),
        .expire_o (settle_end)
    );

    assign poll_active = (st_q.state == S_POLL);

    pll_seq_poll #(.POLL_US(POLL_US), .TIMEOUT_US(LOCK_TIMEOUT_US)) u_poll (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (poll_clr),
        .active_i  (poll_active),
        .us_tick_i (us_tick_i),
        .sample_o  (poll_hit),
        .last_o    (poll_last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        settle_go = 1'b0;
        poll_clr  = 1'b0;
        unique case (st_q.state)
            S_IDLE, S_FAIL: begin
                if (prepare_i) begin
                    st_d.slave  = slave_present_i;
                    st_d.err    = 1'b0;
                    st_d.m.bias = 1'b1;
                    st_d.m.mux  = MUX_ROUTE_ON;
                    if (slave_present_i) begin
                        st_d.s.bias = 1'b1;
                        st_d.s.mux  = MUX_ROUTE_ON;
                    end
                    settle_go  = 1'b1;
                    st_d.state = S_BIAS_WAIT;
                end else if (unprepare_i && st_q.state == S_FAIL) begin
                    st_d.m.clk_en = 1'b0;
                    st_d.state    = S_DN_STOP;
                end
            end
            S_BIAS_WAIT: begin
                if (settle_end) begin
                    st_d.start = 1'b1;
                    poll_clr   = 1'b1;
                    st_d.state = S_POLL;
                end
            end
            S_POLL: begin
                if (poll_hit) begin
                    if (lock_i) begin
                        st_d.on    = 1'b1;
                        st_d.state = S_CLK_OPEN;
                    end else if (poll_last) begin
                        st_d.err   = 1'b1;
                        st_d.state = S_FAIL;
                    end
                end
            end
            S_CLK_OPEN: begin
                st_d.m.clk_en = 1'b1;
                st_d.s.clk_en = st_q.slave;
                st_d.state    = S_BUF_OPEN;
            end
            S_BUF_OPEN: begin
                st_d.m.rbuf = 1'b1;
                st_d.s.rbuf = st_q.slave;
                st_d.done   = 1'b1;
                st_d.state  = S_ON;
            end
            S_ON: begin
                if (unprepare_i) begin
                    st_d.m.clk_en = 1'b0;
                    st_d.state    = S_DN_STOP;
                end
            end
            S_DN_STOP: begin
                st_d.start = 1'b0;
                st_d.state = S_DN_MBUF;
            end
            S_DN_MBUF: begin
                st_d.m.rbuf = 1'b0;
                st_d.state  = S_DN_MMUX;
            end
            S_DN_MMUX: begin
                st_d.m.mux = MUX_ROUTE_OFF;
                st_d.state = S_DN_MBIAS;
            end
            S_DN_MBIAS: begin
                st_d.m.bias = 1'b0;
                settle_go   = 1'b1;
                st_d.state  = S_DN_MWAIT;
            end
            S_DN_MWAIT: begin
                if (settle_end) begin
                    if (st_q.slave) begin
                        st_d.s.clk_en = 1'b0;
                        st_d.state    = S_DN_SBUF;
                    end else begin
                        st_d.on    = 1'b0;
                        st_d.done  = 1'b1;
                        st_d.state = S_IDLE;
                    end
                end
            end
            S_DN_SBUF: begin
                st_d.s.rbuf = 1'b0;
                st_d.state  = S_DN_SMUX;
            end
            S_DN_SMUX: begin
                st_d.s.mux = MUX_ROUTE_OFF;
                st_d.state = S_DN_SBIAS;
            end
            S_DN_SBIAS: begin
                st_d.s.bias = 1'b0;
                settle_go   = 1'b1;
                st_d.state  = S_DN_SWAIT;
            end
            S_DN_SWAIT: begin
                if (settle_end) begin
                    st_d.on    = 1'b0;
                    st_d.done  = 1'b1;
                    st_d.state = S_IDLE;
                end
            end
            default: st_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign m_bias_en_o = st_q.m.bias;
    assign m_sys_mux_o = st_q.m.mux;
    assign m_clk_en_o  = st_q.m.clk_en;
    assign m_rbuf_en_o = st_q.m.rbuf;
    assign s_bias_en_o = st_q.s.bias;
    assign s_sys_mux_o = st_q.s.mux;
    assign s_clk_en_o  = st_q.s.clk_en;
    assign s_rbuf_en_o = st_q.s.rbuf;
    assign pll_start_o = st_q.start;
    assign pll_on_o    = st_q.on;
    assign done_o      = st_q.done;
    assign err_o       = st_q.err;

endmodule

// File: rtl/pll_power_seq_chk.sv
module pll_power_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic prepare_i,
    input logic m_bias_en_o,
    input logic pll_start_o,
    input logic m_clk_en_o,
    input logic s_bias_en_o,
    input logic s_clk_en_o,
    input logic pll_on_o,
    input logic done_o,
    input logic err_o
);
    // R2: the PLL is never started without bias
    p_start_needs_bias_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pll_start_o |-> m_bias_en_o);

    // R5: master clock gate only open while marked on
    p_clk_needs_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        m_clk_en_o |-> pll_on_o);

    // R5: done lasts one cycle
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: start only drops once the clock gate is already closed
    p_gate_before_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_start_o) |-> !m_clk_en_o);

    // R9: slave clock gate never open without slave bias
    p_slave_gate_bias_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_clk_en_o |-> s_bias_en_o);

    // R4: a timed-out PLL is never marked on
    p_on_excludes_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(pll_on_o && err_o));

    // R10: error holds until a power-up request
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !prepare_i) |=> err_o);

endmodule

bind pll_power_seq pll_power_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .prepare_i   (prepare_i),
    .m_bias_en_o (m_bias_en_o),
    .pll_start_o (pll_start_o),
    .m_clk_en_o  (m_clk_en_o),
    .s_bias_en_o (s_bias_en_o),
    .s_clk_en_o  (s_clk_en_o),
    .pll_on_o    (pll_on_o),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/tb_pll_power_seq.sv
module tb_pll_power_seq;
    localparam int CLK_PERIOD = 10;
    localparam int REF_MHZ    = 8;
    localparam int WAIT_CYC   = (250 * REF_MHZ + 999) / 1000;
    localparam int TICK_DIV   = 8;
    localparam int POLL       = 100;
    localparam int TMO        = 5000;
    localparam int WDOG       = 190000;

    logic       clk, rst_n;
    logic       prepare, unprepare, slave_present, lock, us_tick;
    logic       m_bias, m_clk, m_rbuf, start, s_bias, s_clk, s_rbuf, on, done, err;
    logic [7:0] m_mux, s_mux;

    pll_power_seq #(.REF_CLK_MHZ(REF_MHZ)) dut (
        .clk(clk), .rst_n(rst_n), .prepare_i(prepare), .unprepare_i(unprepare),
        .slave_present_i(slave_present), .lock_i(lock), .us_tick_i(us_tick),
        .m_bias_en_o(m_bias), .m_sys_mux_o(m_mux), .pll_start_o(start),
        .m_clk_en_o(m_clk), .m_rbuf_en_o(m_rbuf), .s_bias_en_o(s_bias),
        .s_sys_mux_o(s_mux), .s_clk_en_o(s_clk), .s_rbuf_en_o(s_rbuf),
        .pll_on_o(on), .done_o(done), .err_o(err)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // expected model
    logic       e_mb, e_mc, e_mr, e_st, e_sb, e_sc, e_sr, e_on, e_er, e_dn;
    logic [7:0] e_mm, e_sm;
    logic [25:0] last_pushed = '0;
    logic [25:0] q_v[$];
    int          q_gap[$];
    string       q_tag[$];

    // lock stimulus and tick counting
    bit lock_arm = 1'b0;
    int lock_dly = 0;
    int exp_ticks = 0;
    int tcnt = 0;
    int tdiv = 0;
    bit in_poll_q = 1'b0;
    int cyc = 0;
    int last_chg = 0;
    logic [25:0] prev_vec = '0;

    function automatic logic [25:0] dut_vec();
        return {m_bias, m_mux, start, m_clk, m_rbuf, s_bias, s_mux, s_clk, s_rbuf, on, err, done};
    endfunction

    function automatic logic [25:0] exp_vec();
        return {e_mb, e_mm, e_st, e_mc, e_mr, e_sb, e_sm, e_sc, e_sr, e_on, e_er, e_dn};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic push(input int gap, input string tag);
        logic [25:0] v;
        v = exp_vec();
        if (v != last_pushed) begin
            q_v.push_back(v);
            q_gap.push_back(gap);
            q_tag.push_back(tag);
            last_pushed = v;
        end
    endtask

    // monitor: counts polled ticks, drives tick and lock, pops the scoreboard
    always @(negedge clk) begin
        logic [25:0] vec, ev;
        int g;
        string t;
        cyc++;
        if (rst_n) begin
            if (in_poll_q && us_tick) tcnt++;
            if (!start) tcnt = 0;
            in_poll_q = start && !on && !err;
            vec = dut_vec();
            if (vec != prev_vec) begin
                if (q_v.size() == 0) begin
                    check(1'b0, "R6 unexpected output change", 32'(vec), 32'(prev_vec));
                end else begin
                    ev = q_v.pop_front();
                    g  = q_gap.pop_front();
                    t  = q_tag.pop_front();
                    check(vec == ev, t, 32'(vec), 32'(ev));
                    if (g != 0) check((cyc - last_chg) == g, {t, " step gap"}, 32'(cyc - last_chg), 32'(g));
                end
                if (on && !prev_vec[2]) check(tcnt == exp_ticks, "R3 ticks at lock", 32'(tcnt), 32'(exp_ticks));
                if (err && !prev_vec[1]) check(tcnt == TMO, "R4 ticks at timeout", 32'(tcnt), 32'(TMO));
                last_chg = cyc;
                prev_vec = vec;
            end
        end
        lock = lock_arm && (tcnt >= lock_dly);
        tdiv = (tdiv + 1) % TICK_DIV;
        us_tick = (tdiv == 0);
        if (cyc > WDOG && !finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic pulse_prepare();
        @(negedge clk) prepare = 1'b1;
        @(negedge clk) prepare = 1'b0;
    endtask

    task automatic pulse_unprepare();
        @(negedge clk) unprepare = 1'b1;
        @(negedge clk) unprepare = 1'b0;
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while (q_v.size() != 0 && n < 60000) begin
            @(negedge clk);
            n++;
        end
        repeat (6) @(negedge clk);
        check(q_v.size() == 0, {tag, " expected steps all seen"}, 32'(q_v.size()), 32'd0);
    endtask

    task automatic power_up(input bit slv, input int dly, input bit fail);
        e_mb = 1'b1; e_mm = 8'hC0; e_er = 1'b0;
        if (slv) begin e_sb = 1'b1; e_sm = 8'hC0; end
        push(0, "R1 bias step");
        e_st = 1'b1; push(WAIT_CYC, "R2 start after settle");
        if (!fail) begin
            exp_ticks = POLL * ((dly + 1 + POLL - 1) / POLL);
            e_on = 1'b1; push(0, "R3 marked on");
            e_mc = 1'b1; if (slv) e_sc = 1'b1; push(1, "R5 clock gates");
            e_mr = 1'b1; if (slv) e_sr = 1'b1; e_dn = 1'b1; push(1, "R5 buffers and done");
            e_dn = 1'b0; push(1, "R5 done width");
        end else begin
            e_er = 1'b1; push(0, "R4 timeout error");
        end
        lock_arm = !fail;
        lock_dly = dly;
        slave_present = slv;
        pulse_prepare();
        slave_present = !slv;                  // R11: ignored after capture
        repeat (20) @(negedge clk);
        pulse_prepare();                        // R6: ignored mid-sequence
        pulse_unprepare();                      // R6: ignored mid-sequence
        drain("R3");
    endtask

    task automatic power_down(input bit slv, input bit from_fail);
        int g1;
        g1 = from_fail ? 0 : 1;
        e_mc = 1'b0; push(0, "R7 gate first");
        e_st = 1'b0; push(g1, "R7 stop after gate");
        e_mr = 1'b0; push(g1, "R8 master buffer off");
        e_mm = 8'h00; push(g1, "R8 master mux off");
        e_mb = 1'b0; push(1, "R8 master bias off");
        if (slv) begin
            e_sc = 1'b0; push(WAIT_CYC, "R9 slave gate off");
            e_sr = 1'b0; push(1, "R9 slave buffer off");
            e_sm = 8'h00; push(1, "R9 slave mux off");
            e_sb = 1'b0; push(1, "R9 slave bias off");
        end
        e_on = 1'b0; e_dn = 1'b1; push(WAIT_CYC, slv ? "R9 off and done" : "R8 off and done");
        e_dn = 1'b0; push(1, "R8 done width");
        pulse_unprepare();
        drain("R8");
    endtask

    initial begin
        prepare = 1'b0; unprepare = 1'b0; slave_present = 1'b0;
        lock = 1'b0; us_tick = 1'b0; rst_n = 1'b0;
        {e_mb, e_mc, e_mr, e_st, e_sb, e_sc, e_sr, e_on, e_er, e_dn} = '0;
        e_mm = '0; e_sm = '0;
        repeat (5) @(negedge clk);
        check(dut_vec() == '0, "R12 reset state", 32'(dut_vec()), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        pulse_unprepare();                      // R6: ignored while idle
        repeat (10) @(negedge clk);
        check(dut_vec() == '0, "R6 power-down ignored in idle", 32'(dut_vec()), 32'd0);

        power_up(1'b0, 0, 1'b0);                // first poll
        pulse_prepare();                        // R6: ignored while on
        repeat (10) @(negedge clk);
        check(dut_vec() == last_pushed, "R6 power-up ignored while on", 32'(dut_vec()), 32'(last_pushed));
        power_down(1'b0, 1'b0);

        power_up(1'b1, 250, 1'b0);              // third poll, slave attached
        power_down(1'b1, 1'b0);

        power_up(1'b0, 4999, 1'b0);             // last poll still succeeds
        power_down(1'b0, 1'b0);

        power_up(1'b0, 0, 1'b1);                // no lock: timeout
        repeat (200) @(negedge clk);
        check(err == 1'b1, "R10 error held", 32'(err), 32'd1);
        check(on == 1'b0, "R4 not marked on", 32'(on), 32'd0);
        power_down(1'b0, 1'b1);
        repeat (20) @(negedge clk);
        check(err == 1'b1, "R10 error kept through shutdown", 32'(err), 32'd1);

        power_up(1'b1, 100, 1'b0);              // clears error, second poll
        check(err == 1'b0, "R10 error cleared by power-up", 32'(err), 32'd0);
        power_down(1'b1, 1'b0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule